// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM whose address, control and data registers form a two-stage pipeline. Write data follows its address by the same two enabled clock edges that read data takes to come out. Because of this, a read and a write can be issued on consecutive cycles and the shared data bus never needs an idle turnaround cycle. The word is 18 bits wide and is made of two 9-bit lanes. Each lane holds 8 data bits and 1 parity bit, and each lane has its own active-low write enable.

A cycle either loads a new address or continues a burst. On a load cycle the block samples the operation type (read or write) and three chip-select inputs. A burst-continue cycle does not sample them: it keeps the type and the selection from the last load and steps the two low address bits, wrapping within a group of four. An active-low clock enable freezes every pipeline register. An asynchronous standby input keeps the array contents, ignores all other inputs and releases the bus. The bus is modelled as separate data-in, data-out and output-enable ports, so that the pad logic can build the tri-state driver from them. The array depth is set by a parameter.

Top module: `ntsram_top`

## Requirements
- R1: A read whose address is loaded at enabled edge N sets `dOe` high and puts the array word on `dOut` after enabled edge N+2. The bus is driven for that one data cycle only, and `dOut` is zero whenever `dOe` is low.
- R2: For a write loaded at edge N, `dIn` and `bweN` are sampled at enabled edge N+2. A read or write may be issued on every cycle with no idle cycle, and a read issued right after a write to the same address returns the new data.
- R3: `bweN[0]` low writes bits [8:0] and `bweN[1]` low writes bits [17:9]. A lane whose enable is high keeps its old contents. On cycles that are not write data cycles, `bweN` and `dIn` have no effect.
- R4: `rwSel` (1 = read, 0 = write) is sampled only on load cycles (`advLd` = 0). Burst-continue cycles keep the type latched at the last load, whatever `rwSel` is.
- R5: On an enabled cycle with `advLd` = 1, the address increments within bits [1:0] as 0,1,2,3,0. The upper address bits stay fixed.
- R6: The block is selected only when `ceN1` = 0, `ceN2` = 0 and `ce3` = 1 on a load cycle. A deselected load, and any burst that continues from it, leaves the array unchanged and keeps `dOe` low in its data cycle.
- R7: While `cenN` is high, clock edges have no effect. `dOe` and `dOut` hold their values, and the inputs sampled on those edges are ignored.
- R8: While `snooze` is high, `dOe` is low at once, all other inputs are ignored and the array contents are kept. When `snooze` falls, the pipeline resumes from where it stopped.
- R9: Reset clears all pending operations and the chip-select latch, so `dOe` is low. The array contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset of the pipeline |
| addrIn | input | ADDR_W | Word address, sampled on load cycles |
| rwSel | input | 1 | Operation type on load cycles: 1 read, 0 write |
| advLd | input | 1 | 0 loads a new address, 1 continues the burst |
| ceN1 | input | 1 | Active-low chip select |
| ceN2 | input | 1 | Second active-low chip select |
| ce3 | input | 1 | Active-high chip select |
| bweN | input | LANES | Active-low lane write enables, one per 9-bit lane |
| cenN | input | 1 | Active-low clock enable |
| snooze | input | 1 | Asynchronous active-high retention standby |
| dIn | input | LANES*LANE_W | Write data, sampled in the write data cycle |
| dOut | output | LANES*LANE_W | Read data, zero when not driven |
| dOe | output | 1 | Bus drive enable for the read data cycle |

## Verification
Read data is due just after the second enabled edge that follows the load, and write data is sampled at that same edge. The bench therefore keeps a model of the pipeline indexed by enabled edges. Frozen and standby cycles do not advance that index, and the model works out from it which operation owns the bus in each cycle. All outputs are sampled on the falling edge after the edge that should have changed them. Edges where `cenN` is high or `snooze` is asserted must leave the previous expectation unchanged, with `dOe` forced low during standby.

// File: rtl/ntsram_pkg.sv
package ntsram_pkg;
  // Strobes from the pipeline control to the datapath
  typedef struct packed {
    logic step;      // enabled edge: pipeline moves
    logic loadAddr;  // capture a new address
    logic advAddr;   // burst step on the low bits
    logic arrWrite;  // stage-2 write into the array
    logic arrRead;   // stage-2 read from the array
  } ntsram_strb_t;

  localparam int BURST_W = 2;
endpackage

// File: rtl/ntsram_ctrl.sv
module ntsram_ctrl
  import ntsram_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cenN,
  input  logic         snooze,
  input  logic         advLd,
  input  logic         rwSel,
  input  logic         ceN1,
  input  logic         ceN2,
  input  logic         ce3,
  output ntsram_strb_t strb,
  output logic         busOe
);
  logic latRead, latSel;   // cycle type and selection from the last load
  logic s1Valid;           // stage 1: address registered
  logic s2Valid, s2Read;   // stage 2: one edge later
  logic oeReg;
  logic selNow;

  assign selNow = !ceN1 && !ceN2 && ce3;

  always_comb begin
    strb.step     = !cenN && !snooze;
    strb.loadAddr = strb.step && !advLd;
    strb.advAddr  = strb.step && advLd;
    strb.arrWrite = strb.step && s2Valid && !s2Read;
    strb.arrRead  = strb.step && s2Valid && s2Read;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latRead <= 1'b0;
      latSel  <= 1'b0;
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
      s2Read  <= 1'b0;
      oeReg   <= 1'b0;
    end else if (strb.step) begin
      if (!advLd) begin
        latRead <= rwSel;
        latSel  <= selNow;
        s1Valid <= selNow;
      end else begin
        s1Valid <= latSel;
      end
      s2Valid <= s1Valid;
      s2Read  <= latRead;
      oeReg   <= s2Valid && s2Read;
    end
  end

  assign busOe = oeReg && !snooze;

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.step |=> ($stable(s1Valid) && $stable(s2Valid) && $stable(oeReg)));

  assert_drive_after_read_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oeReg) |-> $past(s2Read));

  assert_type_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.advAddr |=> ($stable(latRead) && $stable(latSel)));

  assert_deselect_noop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadAddr && !selNow) |=> !s1Valid);
endmodule

// File: rtl/ntsram_dpath.sv
module ntsram_dpath
  import ntsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ntsram_strb_t            strb,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [LANES-1:0]        bweN,
  input  logic [LANES*LANE_W-1:0] dIn,
  output logic [LANES*LANE_W-1:0] rdWord
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] burstAddr;  // stage-1 address
  logic [ADDR_W-1:0] s2Addr;     // stage-2 address

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstAddr <= '0;
      s2Addr    <= '0;
    end else begin
      if (strb.loadAddr)
        burstAddr <= addrIn;
      else if (strb.advAddr)
        burstAddr[BURST_W-1:0] <= burstAddr[BURST_W-1:0] + 1'b1;
      if (strb.step)
        s2Addr <= burstAddr;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] laneRd;

    always_ff @(posedge clk) begin
      if (strb.arrWrite && !bweN[g])
        laneMem[s2Addr] <= dIn[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        laneRd <= '0;
      else if (strb.arrRead)
        laneRd <= laneMem[s2Addr];
    end

    assign rdWord[g*LANE_W +: LANE_W] = laneRd;
  end

  assert_burst_upper_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.advAddr |=> ($stable(burstAddr[ADDR_W-1:BURST_W]) &&
                      (burstAddr[BURST_W-1:0] != $past(burstAddr[BURST_W-1:0]))));
endmodule

// File: rtl/ntsram_top.sv
module ntsram_top
  import ntsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic                    rwSel,
  input  logic                    advLd,
  input  logic                    ceN1,
  input  logic                    ceN2,
  input  logic                    ce3,
  input  logic [LANES-1:0]        bweN,
  input  logic                    cenN,
  input  logic                    snooze,
  input  logic [LANES*LANE_W-1:0] dIn,
  output logic [LANES*LANE_W-1:0] dOut,
  output logic                    dOe
);
  ntsram_strb_t            strb;
  logic [LANES*LANE_W-1:0] rdWord;

  ntsram_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cenN(cenN), .snooze(snooze), .advLd(advLd),
    .rwSel(rwSel), .ceN1(ceN1), .ceN2(ceN2), .ce3(ce3),
    .strb(strb), .busOe(dOe)
  );

  ntsram_dpath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .addrIn(addrIn),
    .bweN(bweN), .dIn(dIn), .rdWord(rdWord)
  );

  assign dOut = dOe ? rdWord : '0;
endmodule

// File: tb/ntsram_top_bench.sv
module ntsram_top_bench;
  localparam int AW = 6;
  localparam int LW = 9;
  localparam int NL = 2;
  localparam int DW = LW * NL;
  localparam int DEPTH = 1 << AW;
  localparam int MAXOP = 4096;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, rwSel, advLd, ceN1, ceN2, ce3, cenN, snooze, dOe;
  logic [AW-1:0] addrIn;
  logic [NL-1:0] bweN;
  logic [DW-1:0] dIn, dOut;

  ntsram_top u_ntsram_top (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .rwSel(rwSel), .advLd(advLd),
    .ceN1(ceN1), .ceN2(ceN2), .ce3(ce3), .bweN(bweN), .cenN(cenN),
    .snooze(snooze), .dIn(dIn), .dOut(dOut), .dOe(dOe)
  );

  int vecs = 0, fails = 0;
  logic [DW-1:0] refMem [DEPTH];
  logic          opVal [MAXOP];
  logic          opRd  [MAXOP];
  logic [AW-1:0] opAddr[MAXOP];
  logic [NL-1:0] opBwe [MAXOP];
  logic [DW-1:0] opData[MAXOP];
  int            nEdge = 0;
  logic [AW-1:0] mAddr = '0;
  logic          mRead = 1'b0, mSel = 1'b0;
  logic          expOe = 1'b0;
  logic [DW-1:0] expData = '0;

  localparam logic [2:0] SEL = 3'b001;  // {ceN1, ceN2, ce3}
  localparam logic [2:0] DES = 3'b101;

  function automatic logic [DW-1:0] pat(input int a, input int s);
    return DW'(a * 1103 + s * 2039 + 77);
  endfunction

  task automatic check(input string req, input logic snz);
    logic e;
    e = expOe && !snz;
    vecs++;
    if (dOe !== e) begin
      fails++;
      $display("FAIL %s dOe actual %b expected %b", req, dOe, e);
    end
    vecs++;
    if (dOut !== (e ? expData : '0)) begin
      fails++;
      $display("FAIL %s dOut actual %h expected %h", req, dOut, e ? expData : '0);
    end
  endtask

  // One clock cycle: ld=1 loads, ld=0 continues a burst
  task automatic step(input logic ld, input logic rw, input int a, input logic [2:0] ce,
                      input logic [NL-1:0] bwe, input logic [DW-1:0] wd,
                      input logic ckeN, input logic snz, input string req);
    int e;
    advLd = !ld; rwSel = rw; addrIn = AW'(a); {ceN1, ceN2, ce3} = ce;
    cenN = ckeN; snooze = snz;
    bweN = '0; dIn = ~wd;  // junk unless a write data cycle
    if (!ckeN && !snz) begin
      if (ld) begin mRead = rw; mSel = (ce == SEL); mAddr = AW'(a); end
      else mAddr[1:0] = mAddr[1:0] + 2'd1;
      e = nEdge;
      opVal[e] = mSel; opRd[e] = mRead; opAddr[e] = mAddr; opBwe[e] = bwe; opData[e] = wd;
      nEdge++;
      expOe = 1'b0;
      if (e >= 2 && opVal[e-2]) begin
        if (opRd[e-2]) begin
          expOe = 1'b1;
          expData = refMem[opAddr[e-2]];
        end else begin
          bweN = opBwe[e-2]; dIn = opData[e-2];
          for (int g = 0; g < NL; g++)
            if (!bweN[g]) refMem[opAddr[e-2]][g*LW +: LW] = dIn[g*LW +: LW];
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(req, snz);
  endtask

  task automatic nop(input string req);
    step(1'b1, 1'b1, 0, DES, 2'b00, '0, 1'b0, 1'b0, req);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    nEdge = 0; mAddr = '0; mRead = 1'b0; mSel = 1'b0; expOe = 1'b0;
    check("R9", 1'b0);
    rstN = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; advLd = 1'b0; rwSel = 1'b1; addrIn = '0; {ceN1, ceN2, ce3} = DES;
    bweN = '1; cenN = 1'b1; snooze = 1'b0; dIn = '0;
    for (int a = 0; a < DEPTH; a++) refMem[a] = 'x;
    @(negedge clk);
    doReset();  // R9 reset state

    // R2: back-to-back full writes over the whole array
    for (int a = 0; a < DEPTH; a++) step(1, 0, a, SEL, 2'b00, pat(a, 0), 0, 0, "R2");
    nop("R2"); nop("R2");
    // R1: back-to-back reads of every word
    for (int a = 0; a < DEPTH; a++) step(1, 1, a, SEL, 2'b00, '0, 0, 0, "R1");
    nop("R1"); nop("R1");

    // R2/R3: write then read same address, sweeping lane enables
    for (int i = 0; i < 32; i++) begin
      step(1, 0, i, SEL, NL'(i % 4), pat(i, 1), 0, 0, "R3");
      step(1, 1, i, SEL, 2'b00, '0, 0, 0, "R2");
    end
    nop("R3"); nop("R3");

    // R4/R5: read burst wrapping from low bits 2, rwSel toggled during burst
    step(1, 1, 22, SEL, 2'b00, '0, 0, 0, "R5");
    for (int k = 0; k < 6; k++) step(0, k[0], 0, SEL, 2'b00, '0, 0, 0, "R4");
    nop("R5"); nop("R5");
    // write burst, rwSel high during continue
    step(1, 0, 45, SEL, 2'b00, pat(45, 2), 0, 0, "R5");
    for (int k = 0; k < 4; k++) step(0, 1, 0, SEL, NL'(k), pat(k, 3), 0, 0, "R4");
    nop("R4"); nop("R4");
    step(1, 1, 44, SEL, 2'b00, '0, 0, 0, "R4");
    for (int k = 0; k < 3; k++) step(0, 0, 0, SEL, 2'b00, '0, 0, 0, "R4");
    nop("R4"); nop("R4");

    // R6: every chip-select combination, plus burst after deselect
    for (int c = 0; c < 8; c++) step(1, 0, 48 + c, 3'(c), 2'b00, pat(c, 4), 0, 0, "R6");
    step(1, 0, 56, DES, 2'b00, pat(56, 5), 0, 0, "R6");
    step(0, 0, 0, SEL, 2'b00, pat(57, 5), 0, 0, "R6");
    nop("R6"); nop("R6");
    for (int a = 48; a < 60; a++) step(1, 1, a, SEL, 2'b00, '0, 0, 0, "R6");
    step(1, 1, 0, DES, 2'b00, '0, 0, 0, "R6");
    step(0, 1, 0, SEL, 2'b00, '0, 0, 0, "R6");
    nop("R6"); nop("R6");

    // R7: clock-enable freezes interleaved with junk inputs
    for (int i = 0; i < 16; i++) begin
      step(1, i[0], 8 + i, SEL, 2'b00, pat(i, 6), 0, 0, "R7");
      step(1, 0, 63 - i, SEL, 2'b00, pat(i, 7), 1, 0, "R7");
      if (i % 3 == 0) step(0, 0, 2, SEL, 2'b00, pat(i, 8), 1, 0, "R7");
    end
    nop("R7"); nop("R7");
    for (int a = 8; a < 24; a++) step(1, 1, a, SEL, 2'b00, '0, 0, 0, "R7");
    for (int a = 48; a < 64; a++) step(1, 1, a, SEL, 2'b00, '0, 0, 0, "R7");
    nop("R7"); nop("R7");

    // R8: standby while read data is on the bus, junk write attempts
    step(1, 1, 3, SEL, 2'b00, '0, 0, 0, "R8");
    step(1, 1, 4, SEL, 2'b00, '0, 0, 0, "R8");
    step(1, 1, 5, SEL, 2'b00, '0, 0, 0, "R8");
    for (int k = 0; k < 4; k++) step(1, 0, 3 + k, SEL, 2'b00, pat(k, 9), 0, 1, "R8");
    nop("R8"); nop("R8"); nop("R8");
    for (int a = 3; a < 8; a++) step(1, 1, a, SEL, 2'b00, '0, 0, 0, "R8");
    nop("R8"); nop("R8");

    // R9: reset with a read in flight, contents retained
    step(1, 1, 30, SEL, 2'b00, '0, 0, 0, "R9");
    step(1, 1, 31, SEL, 2'b00, '0, 0, 0, "R9");
    doReset();
    nop("R9"); nop("R9");
    step(0, 0, 0, SEL, 2'b00, pat(0, 10), 0, 0, "R9");
    nop("R9"); nop("R9");
    for (int a = 28; a < 34; a++) step(1, 1, a, SEL, 2'b00, '0, 0, 0, "R9");
    nop("R9"); nop("R9");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule